// File: doc/BRIEF.md
# USB Controller Enable and Reset Sequencer

This block decides the top-level operating condition of a USB device controller. It has four states: reset, macro off, clock stopped and device. It moves between them on a software enable bit, a software clock-freeze bit, the chip-level hardware reset and a one-cycle bus End-Of-Reset pulse. From the state it drives four outputs: a synchronous reset for the controller internals, an attached indication, a suspend indication and a clock enable for the controller clock gate.

Software reaches the block through a small synchronous write port with byte strobes and a combinational read port. Besides the control bits, the port holds a configuration word: a buffer address, a buffer-access flag and speed-selection bits. This word stays intact across End-Of-Reset and across a software disable. Only the chip-level reset clears it. A chip-level reset disables the controller. A bus End-Of-Reset only pulses the internal reset and leaves the device enabled and attached.

Top module: `usb_en_seq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the following hold: `seqState` is 0 (reset), enable reads 0, freeze reads 1, the configuration word reads 0, `ctlRst`=1, `attached`=0, `suspend`=1 and `clkEn`=0.
- R2: Address 0 is the control register, written only when `wrStrb[0]` is set. Its bit 0 is enable and bit 1 is freeze. Address 1 is the configuration register: bits 10:0 are the buffer address, bit 11 is buffer access and bits 13:12 are speed. `wrStrb[0]` writes bits 7:0 and `wrStrb[1]` writes bits 15:8. `rdData` follows `rdAddr` combinationally, and unused bits read 0.
- R3: In states 0 (reset) and 1 (macro off), `ctlRst`=1, `attached`=0, `suspend`=1 and `clkEn`=0. Freeze reads 1, and a write that leaves enable at 0 cannot clear freeze.
- R4: A control write of enable=1, freeze=0 moves the block to state 3 (device) on that clock edge. In state 3, `ctlRst`=0, `attached`=1, `suspend`=0 and `clkEn`=1.
- R5: A control write with enable=0 made from state 2 or 3 moves the block to state 1 (macro off) on that edge, and freeze then reads 1.
- R6: A control write of enable=1, freeze=1 moves the block to state 2 (clock stopped). There `clkEn`=0, `attached`=1, `ctlRst`=0 and `suspend`=0. Writing freeze=0 with enable=1 returns the block to state 3.
- R7: An End-Of-Reset pulse in state 3 raises `ctlRst` for exactly the next cycle. Enable stays 1 and the state stays 3.
- R8: An End-Of-Reset pulse in any state other than 3 has no effect on the outputs or on the registers.
- R9: When an End-Of-Reset pulse comes in the same cycle as a control write that clears enable, the disable takes effect and the block enters state 1.
- R10: Software can write the configuration word in every state. Enable changes and End-Of-Reset leave it unchanged.
- R11: A chip-level reset asserted during device operation returns the block at once to the R1 condition. This includes clearing the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller register clock |
| rst_n | input | 1 | Chip-level hardware reset, asynchronous, active low |
| wrEn | input | 1 | Register write request |
| wrAddr | input | 1 | Write address: 0 control, 1 configuration |
| wrStrb | input | 2 | Byte write strobes |
| wrData | input | 16 | Write data |
| eorPulse | input | 1 | Bus End-Of-Reset event, one cycle wide |
| rdAddr | input | 1 | Read address |
| rdData | output | 16 | Combinational readback |
| ctlRst | output | 1 | Synchronous reset to controller internals |
| attached | output | 1 | Controller enabled and attached |
| suspend | output | 1 | Suspend indication |
| clkEn | output | 1 | Controller clock gate enable |
| seqState | output | 2 | Current state: 0 reset, 1 macro off, 2 clock stopped, 3 device |

## Verification
The assertions assume that `eorPulse` is never high for two cycles in a row. They also assume that every register write lasts exactly one cycle, so that a property triggered by a write sees the state that write produced. The stimulus drives End-Of-Reset only as isolated single-cycle pulses, and it releases every write on the next falling edge. The only case where End-Of-Reset and a write share a cycle is the one deliberate collision with a clear of enable. The chip-level reset is applied away from clock edges, and all properties are disabled while it is low.

// File: rtl/usb_en_seq_pkg.sv
package usb_en_seq_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_OFF     = 2'd1,
    ST_CLKSTOP = 2'd2,
    ST_DEVICE  = 2'd3
  } seq_state_e;

  // strobes from control to the configuration datapath
  typedef struct packed {
    logic [LANES-1:0] cfgWr;
  } dp_strobe_t;
endpackage

// File: rtl/usb_en_seq_ctrl.sv
module usb_en_seq_ctrl
  import usb_en_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [LANES-1:0] wrStrb,
  input  logic [1:0]       wrCtl,
  input  logic             eorPulse,
  output seq_state_e       state,
  output logic             enQ,
  output logic             frzQ,
  output logic             eorRstQ,
  output dp_strobe_t       strobe
);
  logic       ctrlWr;
  logic       enNext;
  logic       frzNext;
  logic       eorHit;
  seq_state_e stateNext;

  assign ctrlWr       = wrEn && !wrAddr && wrStrb[0];
  assign strobe.cfgWr = {LANES{wrEn && wrAddr}} & wrStrb;

  always_comb begin
    enNext  = ctrlWr ? wrCtl[0] : enQ;
    // freeze is held at 1 whenever the controller is disabled
    frzNext = !enNext ? 1'b1 : (ctrlWr ? wrCtl[1] : frzQ);
    // End-Of-Reset only counts in device state and loses to a disable
    eorHit  = eorPulse && (state == ST_DEVICE) && enNext;
    if (!enNext) begin
      stateNext = enQ ? ST_OFF : state;
    end else begin
      stateNext = frzNext ? ST_CLKSTOP : ST_DEVICE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESET;
      enQ     <= 1'b0;
      frzQ    <= 1'b1;
      eorRstQ <= 1'b0;
    end else begin
      state   <= stateNext;
      enQ     <= enNext;
      frzQ    <= frzNext;
      eorRstQ <= eorHit;
    end
  end
endmodule

// File: rtl/usb_en_seq_dp.sv
module usb_en_seq_dp
  import usb_en_seq_pkg::*;
#(
  parameter int BUF_AW = 11,
  parameter int SPD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  input  logic              enQ,
  input  logic              frzQ,
  output logic [DATA_W-1:0] rdData
);
  localparam int CFG_W = BUF_AW + 1 + SPD_W;
  localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((32'd1 << CFG_W) - 32'd1);

  logic [DATA_W-1:0] cfgQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgQ[8*i +: 8] <= 8'h00;
      end else if (strobe.cfgWr[i]) begin
        cfgQ[8*i +: 8] <= wrData[8*i +: 8] & CFG_MASK[8*i +: 8];
      end
    end
  end

  always_comb begin
    if (rdAddr) begin
      rdData = cfgQ;
    end else begin
      rdData = {{(DATA_W-2){1'b0}}, frzQ, enQ};
    end
  end
endmodule

// File: rtl/usb_en_seq.sv
module usb_en_seq
  import usb_en_seq_pkg::*;
#(
  parameter int BUF_AW = 11,
  parameter int SPD_W  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [1:0]  wrStrb,
  input  logic [15:0] wrData,
  input  logic        eorPulse,
  input  logic        rdAddr,
  output logic [15:0] rdData,
  output logic        ctlRst,
  output logic        attached,
  output logic        suspend,
  output logic        clkEn,
  output logic [1:0]  seqState
);
  seq_state_e state;
  logic       enQ;
  logic       frzQ;
  logic       eorRstQ;
  logic       offState;
  dp_strobe_t strobe;

  usb_en_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrStrb  (wrStrb),
    .wrCtl   (wrData[1:0]),
    .eorPulse(eorPulse),
    .state   (state),
    .enQ     (enQ),
    .frzQ    (frzQ),
    .eorRstQ (eorRstQ),
    .strobe  (strobe)
  );

  usb_en_seq_dp #(.BUF_AW(BUF_AW), .SPD_W(SPD_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .enQ   (enQ),
    .frzQ  (frzQ),
    .rdData(rdData)
  );

  assign offState = (state == ST_RESET) || (state == ST_OFF);
  assign ctlRst   = offState || eorRstQ;
  assign attached = !offState;
  assign suspend  = offState;
  assign clkEn    = (state == ST_DEVICE);
  assign seqState = state;
endmodule

// File: rtl/usb_en_seq_chk.sv
module usb_en_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        wrAddr,
  input logic [1:0]  wrStrb,
  input logic [15:0] wrData,
  input logic        eorPulse,
  input logic        rdAddr,
  input logic [15:0] rdData,
  input logic        ctlRst,
  input logic        attached,
  input logic        suspend,
  input logic        clkEn,
  input logic [1:0]  seqState
);
  localparam logic [1:0] S_RST = 2'd0;
  localparam logic [1:0] S_OFF = 2'd1;
  localparam logic [1:0] S_STP = 2'd2;
  localparam logic [1:0] S_DEV = 2'd3;

  logic ctlWrite;
  assign ctlWrite = wrEn && !wrAddr && wrStrb[0];

  AST_OFF_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState == S_RST || seqState == S_OFF) |-> (ctlRst && !attached && suspend && !clkEn)); // R3
  AST_FRZ_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!attached && !rdAddr) |-> rdData[1]); // R3
  AST_GATE_DEVICE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState != S_DEV) |-> !clkEn); // R6
  AST_ENABLE_TO_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrite && wrData[1:0] == 2'b01) |=> (seqState == S_DEV && attached && clkEn)); // R4
  AST_CLEAR_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrite && !wrData[0] && attached) |=> (seqState == S_OFF && !attached)); // R5
  AST_EOR_KEEPS_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (eorPulse && seqState == S_DEV && !ctlWrite) |=> (ctlRst && attached && seqState == S_DEV)); // R7
  AST_EOR_IGNORED_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (eorPulse && seqState == S_STP && !ctlWrite) |=> (!ctlRst && seqState == S_STP)); // R8
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (eorPulse && ctlWrite && !wrData[0] && seqState == S_DEV) |=> (seqState == S_OFF)); // R9
endmodule

bind usb_en_seq usb_en_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrStrb  (wrStrb),
  .wrData  (wrData),
  .eorPulse(eorPulse),
  .rdAddr  (rdAddr),
  .rdData  (rdData),
  .ctlRst  (ctlRst),
  .attached(attached),
  .suspend (suspend),
  .clkEn   (clkEn),
  .seqState(seqState)
);

// File: tb/usb_en_seq_test.sv
`timescale 1ns/1ps
module usb_en_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [1:0]  wrStrb = 2'b00;
  logic [15:0] wrData = 16'h0000;
  logic        eorPulse = 1'b0;
  logic        rdAddr = 1'b0;
  logic [15:0] rdData;
  logic        ctlRst, attached, suspend, clkEn;
  logic [1:0]  seqState;

  int    nRun = 0;
  int    nFail = 0;
  bit    done = 1'b0;
  bit    started = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  int mEn, mFrz, mSt, mEorRst, mCfg;

  always #5 clk = ~clk;

  usb_en_seq uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrStrb(wrStrb),
    .wrData(wrData), .eorPulse(eorPulse), .rdAddr(rdAddr), .rdData(rdData),
    .ctlRst(ctlRst), .attached(attached), .suspend(suspend), .clkEn(clkEn),
    .seqState(seqState)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mEn = 0; mFrz = 1; mSt = 0; mEorRst = 0; mCfg = 0;
    end else begin
      bit ctlW;
      int nEn, nFrz;
      ctlW = wrEn && !wrAddr && wrStrb[0];
      nEn  = ctlW ? int'(wrData[0]) : mEn;
      nFrz = (nEn == 0) ? 1 : (ctlW ? int'(wrData[1]) : mFrz);
      mEorRst = (eorPulse && mSt == 3 && nEn == 1) ? 1 : 0;
      if (nEn == 0) mSt = (mEn == 1) ? 1 : mSt;
      else          mSt = (nFrz == 1) ? 2 : 3;
      if (wrEn && wrAddr && wrStrb[0]) mCfg = (mCfg & 'h3F00) | (int'(wrData) & 'h00FF);
      if (wrEn && wrAddr && wrStrb[1]) mCfg = (mCfg & 'h00FF) | (int'(wrData) & 'h3F00);
      mEn = nEn; mFrz = nFrz;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      bit off;
      off = (mSt < 2);
      check(curReq, "seqState", int'(seqState), mSt);
      check(curReq, "ctlRst", int'(ctlRst), (off || mEorRst == 1) ? 1 : 0);
      check(curReq, "attached", int'(attached), off ? 0 : 1);
      check(curReq, "suspend", int'(suspend), off ? 1 : 0);
      check(curReq, "clkEn", int'(clkEn), (mSt == 3) ? 1 : 0);
      rdAddr = 1'b0;
      #1 check(curReq, "ctrl readback", int'(rdData), mFrz * 2 + mEn);
      rdAddr = 1'b1;
      #1 check(curReq, "cfg readback", int'(rdData), mCfg);
      rdAddr = 1'b0;
    end
  end

  task automatic wrReg(bit addr, logic [1:0] strb, logic [15:0] data, bit eor = 1'b0);
    @(negedge clk);
    #3;
    wrEn = 1'b1; wrAddr = addr; wrStrb = strb; wrData = data; eorPulse = eor;
    @(negedge clk);
    #3;
    wrEn = 1'b0; wrStrb = 2'b00; eorPulse = 1'b0;
  endtask

  task automatic eor();
    @(negedge clk);
    #3 eorPulse = 1'b1;
    @(negedge clk);
    #3 eorPulse = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    started = 1'b1;
    curReq = "R1";
    idle(3);
    #3 rst_n = 1'b1;
    idle(2);

    curReq = "R3";
    wrReg(1'b0, 2'b01, 16'h0000);     // freeze=0 with enable=0: ignored
    idle(2);

    curReq = "R2";
    wrReg(1'b0, 2'b10, 16'h0001);     // wrong lane: control not written
    idle(1);
    wrReg(1'b1, 2'b11, 16'hFFFF);     // unused bits read 0
    idle(1);

    curReq = "R10";
    wrReg(1'b1, 2'b01, 16'h00A5);
    wrReg(1'b1, 2'b10, 16'h2B00);
    idle(1);

    curReq = "R4";
    wrReg(1'b0, 2'b01, 16'h0001);
    idle(2);

    curReq = "R7";
    eor();
    idle(3);

    curReq = "R6";
    wrReg(1'b0, 2'b01, 16'h0003);
    idle(2);
    curReq = "R8";
    eor();
    idle(2);
    curReq = "R6";
    wrReg(1'b0, 2'b01, 16'h0001);
    idle(2);

    curReq = "R5";
    wrReg(1'b0, 2'b01, 16'h0002);
    idle(2);
    curReq = "R8";
    eor();
    idle(2);
    curReq = "R10";
    wrReg(1'b1, 2'b10, 16'h1500);
    idle(1);

    curReq = "R4";
    wrReg(1'b0, 2'b01, 16'h0001);
    idle(1);
    curReq = "R9";
    wrReg(1'b0, 2'b01, 16'h0000, 1'b1);
    idle(3);

    curReq = "R6";
    wrReg(1'b0, 2'b01, 16'h0003);     // enable straight into clock stopped
    idle(1);
    curReq = "R5";
    wrReg(1'b0, 2'b01, 16'h0000);
    idle(1);

    curReq = "R11";
    wrReg(1'b0, 2'b01, 16'h0001);
    wrReg(1'b1, 2'b11, 16'h3ABC);
    idle(2);
    @(posedge clk);
    #2 rst_n = 1'b0;
    idle(2);
    #3 rst_n = 1'b1;
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule